// File: doc/BRIEF.md
# Divider Factor Search Engine

This unit picks the divider settings for a clock whose output rate is the parent rate shifted right by an exponent P and then divided, with truncation, by a linear divisor M. A start strobe loads a parent rate, a requested target rate and the largest M and P that the divider fields allow. The engine then tries every (P, M) pair in a fixed order. For each pair it computes the candidate rate with a serial restoring divider. It keeps the candidate that lands closest to the target without going above it.

When the last pair has been tried, the engine pulses a done flag. It then presents the chosen M, the chosen P and the rate they produce. These outputs stay unchanged until the next accepted start. If no pair was ever accepted, the results stay at zero and an error flag is raised. A configuration agent uses the outputs to program the divider fields. Writing those fields and selecting among parent clocks are handled elsewhere.

Top module: `mp_factor_search`

## Requirements
- R1: After reset, done_o and no_fit_o are 0, and best_m_o, best_p_o and best_rate_o are 0.
- R2: The candidate rate for a pair is floor((parent >> P) / M), and best_rate_o always equals that value for the reported best_m_o and best_p_o when a fit exists.
- R3: Candidates are visited with P as the outer loop, counting from 0 up to max_p_i inclusive, and M as the inner loop, counting from 1 up to max_m_i inclusive. Every pair is tried exactly once.
- R4: A candidate whose rate is above the target is never accepted, so best_rate_o never exceeds the target.
- R5: A candidate replaces the held best only if its distance below the target is strictly smaller. On a tie the pair visited first wins, which is the lowest P and then the lowest M.
- R6: At done, the result is the pair whose rate is closest to the target from below, among all pairs in range.
- R7: If no candidate is accepted, best_m_o, best_p_o and best_rate_o stay 0 and no_fit_o is 1 at done. This covers a target of 0, and also the case where every candidate rate is 0. Otherwise no_fit_o is 0.
- R8: done_o is high for exactly one cycle per search. The result outputs hold their values until the next accepted start.
- R9: A start strobe that arrives while a search is in progress is ignored. The running search finishes with the operands it loaded.
- R10: The operands are captured when start is accepted. max_m_i may range from 1 to 2^M_FW, and max_p_i from 0 to 2^P_FW-1. A max_m_i of 0 yields no candidates and ends with no_fit_o set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when the engine is idle |
| parent_rate_i | input | RATE_W | Parent clock rate |
| target_rate_i | input | RATE_W | Requested rate |
| max_m_i | input | M_FW+1 | Largest linear divisor to try |
| max_p_i | input | P_FW | Largest shift exponent to try |
| done_o | output | 1 | One-cycle pulse when the search completes |
| no_fit_o | output | 1 | Set at done when no candidate was accepted |
| best_m_o | output | M_FW+1 | Chosen linear divisor (0 when no fit) |
| best_p_o | output | P_FW | Chosen shift exponent |
| best_rate_o | output | RATE_W | Rate produced by the chosen pair |

## Verification
The assertions take for granted that the divisor handed to the serial divider is never zero. This holds because M starts at 1 and a max_m_i of 0 bypasses the divider entirely. The assertions also assume that the held target and parent do not change between candidates, which the capture register guarantees once start is accepted.

The random stimulus keeps max_m_i within 1 to 2^M_FW and max_p_i within its field. It derives targets near real divider outputs and also well away from them. Separate directed cases drive a zero max_m_i, a zero target, ties, and a start strobe in the middle of a search.

// File: rtl/mp_search_pkg.sv
package mp_search_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_LAUNCH = 2'd1,
    S_WAIT   = 2'd2,
    S_FIN    = 2'd3
  } srch_state_e;
endpackage

// File: rtl/mp_serial_div.sv
module mp_serial_div #(
  parameter int W  = 24,
  parameter int DW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          valid_o,
  output logic [W-1:0]  quotient_o
);
  localparam int CW = $clog2(W + 1);
  localparam int XW = W + DW + 1;

  logic [W-1:0]  quo_q, dvd_q;
  logic [DW:0]   rem_q;
  logic [DW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, valid_q;

  logic [DW:0] shifted, diff;
  logic        ge;

  assign shifted = {rem_q[DW-1:0], quo_q[W-1]};
  assign ge      = shifted >= {1'b0, dvs_q};
  assign diff    = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q   <= '0;
      dvd_q   <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      quo_q   <= dividend_i;
      dvd_q   <= dividend_i;
      dvs_q   <= divisor_i;
      rem_q   <= '0;
      cnt_q   <= CW'(W);
      run_q   <= 1'b1;
      valid_q <= 1'b0;
    end else if (run_q) begin
      quo_q <= {quo_q[W-2:0], ge};
      rem_q <= ge ? diff : shifted;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_q   <= 1'b0;
        valid_q <= 1'b1;
      end
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o    = valid_q;
  assign quotient_o = quo_q;

  // R2: the quotient/remainder pair reconstructs the dividend
  a_r2_div_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> ((XW'(quo_q) * XW'(dvs_q) + XW'(rem_q)) == XW'(dvd_q))
                && (rem_q < {1'b0, dvs_q}));
endmodule

// File: rtl/mp_cand_iter.sv
module mp_cand_iter #(
  parameter int MVW = 5,
  parameter int PW  = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           init_i,
  input  logic           step_i,
  input  logic [MVW-1:0] max_m_i,
  input  logic [PW-1:0]  max_p_i,
  output logic [MVW-1:0] m_o,
  output logic [PW-1:0]  p_o,
  output logic           last_o
);
  logic [MVW-1:0] m_q;
  logic [PW-1:0]  p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= MVW'(1);
      p_q <= '0;
    end else if (init_i) begin
      m_q <= MVW'(1);
      p_q <= '0;
    end else if (step_i) begin
      if (m_q == max_m_i) begin
        m_q <= MVW'(1);
        p_q <= p_q + 1'b1;
      end else begin
        m_q <= m_q + 1'b1;
      end
    end
  end

  assign m_o    = m_q;
  assign p_o    = p_q;
  assign last_o = (m_q == max_m_i) && (p_q == max_p_i);

  a_r3_m_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (m_q >= MVW'(1)) && (m_q <= max_m_i) && (p_q <= max_p_i));

  a_r3_inner_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_i && m_q != max_m_i) |=> (m_q == $past(m_q) + 1'b1) && $stable(p_q));

  a_r3_outer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_i && m_q == max_m_i) |=> (m_q == MVW'(1)) && (p_q == $past(p_q) + 1'b1));
endmodule

// File: rtl/mp_best_track.sv
module mp_best_track #(
  parameter int RW  = 24,
  parameter int MVW = 5,
  parameter int PW  = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           cand_valid_i,
  input  logic [RW-1:0]  cand_rate_i,
  input  logic [MVW-1:0] cand_m_i,
  input  logic [PW-1:0]  cand_p_i,
  input  logic [RW-1:0]  target_i,
  output logic [RW-1:0]  best_rate_o,
  output logic [MVW-1:0] best_m_o,
  output logic [PW-1:0]  best_p_o
);
  logic [RW-1:0]  rate_q;
  logic [MVW-1:0] m_q;
  logic [PW-1:0]  p_q;
  logic           fits, closer, take;

  assign fits   = cand_rate_i <= target_i;
  // strict compare: the earlier candidate keeps a tie
  assign closer = (target_i - cand_rate_i) < (target_i - rate_q);
  assign take   = cand_valid_i && fits && closer;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      m_q    <= '0;
      p_q    <= '0;
    end else if (clear_i) begin
      rate_q <= '0;
      m_q    <= '0;
      p_q    <= '0;
    end else if (take) begin
      rate_q <= cand_rate_i;
      m_q    <= cand_m_i;
      p_q    <= cand_p_i;
    end
  end

  assign best_rate_o = rate_q;
  assign best_m_o    = m_q;
  assign best_p_o    = p_q;

  a_r5_rate_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> rate_q >= $past(rate_q));

  a_r4_no_overshoot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_i && !clear_i && cand_rate_i > target_i) |=> $stable(m_q) && $stable(rate_q));
endmodule

// File: rtl/mp_factor_search.sv
module mp_factor_search
  import mp_search_pkg::*;
#(
  parameter int RATE_W = 24,
  parameter int M_FW   = 4,
  parameter int P_FW   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] parent_rate_i,
  input  logic [RATE_W-1:0] target_rate_i,
  input  logic [M_FW:0]     max_m_i,
  input  logic [P_FW-1:0]   max_p_i,
  output logic              done_o,
  output logic              no_fit_o,
  output logic [M_FW:0]     best_m_o,
  output logic [P_FW-1:0]   best_p_o,
  output logic [RATE_W-1:0] best_rate_o
);
  localparam int MV_W = M_FW + 1;

  srch_state_e       state_q;
  logic [RATE_W-1:0] par_q, tgt_q;
  logic [MV_W-1:0]   mmax_q;
  logic [P_FW-1:0]   pmax_q;
  logic              done_q, nofit_q;

  logic              accept, div_start, div_valid, step, last;
  logic [MV_W-1:0]   cur_m;
  logic [P_FW-1:0]   cur_p;
  logic [RATE_W-1:0] dividend, quotient;

  assign accept    = (state_q == S_IDLE) && start_i;
  assign div_start = (state_q == S_LAUNCH);
  assign step      = (state_q == S_WAIT) && div_valid && !last;
  assign dividend  = par_q >> cur_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      par_q   <= '0;
      tgt_q   <= '0;
      mmax_q  <= '0;
      pmax_q  <= '0;
      done_q  <= 1'b0;
      nofit_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          par_q   <= parent_rate_i;
          tgt_q   <= target_rate_i;
          mmax_q  <= max_m_i;
          pmax_q  <= max_p_i;
          nofit_q <= 1'b0;
          state_q <= (max_m_i == '0) ? S_FIN : S_LAUNCH;
        end
        S_LAUNCH: state_q <= S_WAIT;
        S_WAIT: if (div_valid) state_q <= last ? S_FIN : S_LAUNCH;
        S_FIN: begin
          done_q  <= 1'b1;
          nofit_q <= (best_m_o == '0);
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  mp_cand_iter #(.MVW(MV_W), .PW(P_FW)) u_iter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (accept),
    .step_i  (step),
    .max_m_i (mmax_q),
    .max_p_i (pmax_q),
    .m_o     (cur_m),
    .p_o     (cur_p),
    .last_o  (last)
  );

  mp_serial_div #(.W(RATE_W), .DW(MV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (dividend),
    .divisor_i  (cur_m),
    .valid_o    (div_valid),
    .quotient_o (quotient)
  );

  mp_best_track #(.RW(RATE_W), .MVW(MV_W), .PW(P_FW)) u_best (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (accept),
    .cand_valid_i (state_q == S_WAIT && div_valid),
    .cand_rate_i  (quotient),
    .cand_m_i     (cur_m),
    .cand_p_i     (cur_p),
    .target_i     (tgt_q),
    .best_rate_o  (best_rate_o),
    .best_m_o     (best_m_o),
    .best_p_o     (best_p_o)
  );

  assign done_o   = done_q;
  assign no_fit_o = nofit_q;

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && start_i) |=> $stable(tgt_q) && $stable(par_q) && $stable(mmax_q));

  a_r4_result_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> best_rate_o <= tgt_q);

  a_r7_nofit_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && no_fit_o) |-> (best_rate_o == '0) && (best_p_o == '0) && (best_m_o == '0));

  a_r8_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !start_i) |=> $stable(best_m_o) && $stable(best_rate_o));
endmodule

// File: tb/tb_mp_factor_search.sv
`timescale 1ns/1ps
module tb_mp_factor_search;
  localparam int RATE_W = 24;
  localparam int M_FW   = 4;
  localparam int P_FW   = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [RATE_W-1:0] parent_rate_i = '0;
  logic [RATE_W-1:0] target_rate_i = '0;
  logic [M_FW:0]     max_m_i = '0;
  logic [P_FW-1:0]   max_p_i = '0;
  logic              done_o, no_fit_o;
  logic [M_FW:0]     best_m_o;
  logic [P_FW-1:0]   best_p_o;
  logic [RATE_W-1:0] best_rate_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mp_factor_search #(.RATE_W(RATE_W), .M_FW(M_FW), .P_FW(P_FW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .parent_rate_i(parent_rate_i), .target_rate_i(target_rate_i),
    .max_m_i(max_m_i), .max_p_i(max_p_i),
    .done_o(done_o), .no_fit_o(no_fit_o),
    .best_m_o(best_m_o), .best_p_o(best_p_o), .best_rate_o(best_rate_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference from R2/R3/R5: ordered sweep, strict improvement
  task automatic ref_search(input longint par, input longint tgt, input int mm, input int pm,
                            output int bm, output int bp, output longint br);
    bm = 0; bp = 0; br = 0;
    for (int p = 0; p <= pm; p++)
      for (int m = 1; m <= mm; m++) begin
        longint r = (par >> p) / m;
        if (r <= tgt && (tgt - r) < (tgt - br)) begin
          br = r; bm = m; bp = p;
        end
      end
  endtask

  task automatic launch(input longint par, input longint tgt, input int mm, input int pm);
    @(negedge clk);
    parent_rate_i = RATE_W'(par);
    target_rate_i = RATE_W'(tgt);
    max_m_i = (M_FW+1)'(mm);
    max_p_i = P_FW'(pm);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done_o) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_result(input longint par, input longint tgt, input int mm, input int pm,
                              input string tag);
    int em, ep; longint er; bit seen;
    ref_search(par, tgt, mm, pm, em, ep, er);
    wait_done(seen);
    chk(seen, {tag, " R8 done seen"}, seen, 1);
    chk(best_m_o == em, {tag, " R6 best_m"}, best_m_o, em);
    chk(best_p_o == ep, {tag, " R5 best_p"}, best_p_o, ep);
    chk(best_rate_o == er, {tag, " R2 best_rate"}, best_rate_o, er);
    chk(best_rate_o <= tgt, {tag, " R4 no overshoot"}, best_rate_o, tgt);
    chk(no_fit_o == (em == 0), {tag, " R7 no_fit"}, no_fit_o, em == 0);
    @(negedge clk);
    chk(!done_o, {tag, " R8 done one cycle"}, done_o, 0);
    repeat (3) @(negedge clk);
    chk(best_m_o == em && best_rate_o == er, {tag, " R8 result held"}, best_rate_o, er);
  endtask

  task automatic run(input longint par, input longint tgt, input int mm, input int pm,
                     input string tag);
    launch(par, tgt, mm, pm);
    check_result(par, tgt, mm, pm, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done_o && !no_fit_o, "R1 flags at reset", {done_o, no_fit_o}, 0);
    chk(best_m_o == 0 && best_p_o == 0 && best_rate_o == 0, "R1 results at reset", best_rate_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    run(1000, 1000, 16, 3, "exact parent");          // R6: m=1 p=0
    run(100, 50, 16, 3, "tie m2p0 vs m1p1");         // R5: earliest wins
    chk(best_m_o == 2 && best_p_o == 0, "R5 tie earliest", best_m_o, 2);
    run(1000, 0, 16, 3, "zero target");              // R7
    chk(no_fit_o == 1, "R7 zero target flag", no_fit_o, 1);
    run(3, 1, 16, 3, "small parent");                // R3 covers p loop
    run(1000, 999, 0, 3, "max_m zero");              // R10
    chk(no_fit_o == 1 && best_m_o == 0, "R10 max_m zero no fit", best_m_o, 0);
    run(24'hFFFFFF, 24'h0FFFFF, 16, 3, "max parent"); // R3 full range
    run(1000, 40, 16, 0, "p fixed zero");            // R3 only p=0
    run(5, 3, 16, 3, "all below small");
    run(16, 1000, 1, 0, "single candidate");         // R3 one pair

    // R9: second strobe mid search is ignored
    launch(777777, 50000, 16, 3);
    repeat (30) @(negedge clk);
    parent_rate_i = 24'd12345; target_rate_i = 24'd7; max_m_i = 5'd3; max_p_i = 2'd1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check_result(777777, 50000, 16, 3, "R9 mid start ignored");

    // random mix
    for (int n = 0; n < 32; n++) begin
      longint par, tgt; int mm, pm;
      par = longint'($urandom_range(1, (1 << RATE_W) - 1));
      mm = int'($urandom_range(1, 1 << M_FW));
      pm = int'($urandom_range(0, (1 << P_FW) - 1));
      case ($urandom_range(0, 2))
        0: tgt = (par >> $urandom_range(0, 3)) / $urandom_range(1, 16);
        1: tgt = longint'($urandom_range(0, (1 << RATE_W) - 1));
        default: tgt = ((par >> $urandom_range(0, 3)) / $urandom_range(1, 16)) + $urandom_range(0, 9);
      endcase
      if (tgt > (1 << RATE_W) - 1) tgt = (1 << RATE_W) - 1;
      run(par, tgt, mm, pm, "R3 R6 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule